// File: doc/BRIEF.md
# Sleep Mode Clock-Gating Controller

This block decides which clock domains of a small microcontroller core keep running. Software writes a control register that holds a sleep-enable bit and a two-bit mode field. When the core signals that it has executed its sleep instruction, the controller halts the CPU and gates the domains that the selected mode does not need. The domains are CPU, flash, I/O, ADC and the main oscillator enable. While the core sleeps, the controller watches the wake sources and accepts only those that the active mode permits.

On a wake it may first hold the oscillator alone for a programmable start-up count. This happens only when the oscillator was switched off. It then keeps the CPU halted for a fixed number of cycles with the other domains running, and releases the CPU with a one-cycle vector strobe. A vector-select output tells the core whether to jump to the reset vector or to take the interrupt. All enables come from flops clocked by the free-running reference clock, so they cannot glitch.

Top module: `sleep_clkgate_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released with no sleep, all five enables and `cpu_run` are 1, and `vec_go` and `vec_rst` are 0.
- R2: A `slp_req` pulse seen while the stored sleep-enable bit is 0 is ignored: `cpu_run` and every enable stay 1.
- R3: Mode 2'b00 (Idle) gates only the CPU and flash clocks, and `cpu_run` drops. The enables {osc,adc,io,flash,cpu} read 5'b11100 one cycle after the accepted request.
- R4: Mode 2'b01 (ADC quiet) gates the CPU, flash and I/O clocks, giving enables 5'b11000.
- R5: Mode 2'b10 (Power-down) and the reserved code 2'b11 gate every clock and drop the oscillator enable, giving enables 5'b00000.
- R6: The wake inputs are `wake_ext0`, `wake_pinchg`, `wake_wdog`, `wake_adc` and `wake_io`. Idle accepts all five. ADC quiet accepts all except `wake_io`. Power-down and reserved accept only `wake_ext0`, `wake_pinchg` and `wake_wdog`. A source that is not accepted leaves the core asleep.
- R7: `wake_ext0` is level sensitive. It wakes the core only after it has been high on EXT0_FILT (default 2) consecutive clock edges. A one-cycle pulse does not wake the core.
- R8: A wake from Power-down or reserved with `su_cycles` = N > 0 first spends N cycles with enables 5'b10000. Idle and ADC quiet, or N = 0, skip this phase.
- R9: After any start-up phase the CPU stays halted for HALT_CYC (default 4) cycles with enables 5'b11110. `cpu_run` then rises together with a one-cycle `vec_go` pulse.
- R10: A `core_rst` pulse during sleep wakes the core by itself, and `vec_rst` is 1 when `vec_go` fires. A wake by interrupt gives `vec_rst` = 0. `vec_rst` does not change while the CPU runs.
- R11: `cfg_we` loads `cfg_slp_en` and `cfg_mode`. The mode in effect is captured when sleep is entered, so a write during sleep does not change the current gating but applies to the next sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_slp_en | input | 1 | Sleep-enable bit to write |
| cfg_mode | input | 2 | Sleep mode code to write |
| slp_req | input | 1 | Sleep instruction executed |
| core_rst | input | 1 | Reset event request |
| wake_ext0 | input | 1 | External interrupt 0, level |
| wake_pinchg | input | 1 | Pin-change interrupt |
| wake_wdog | input | 1 | Watchdog interrupt |
| wake_adc | input | 1 | ADC conversion done |
| wake_io | input | 1 | Other I/O interrupt |
| su_cycles | input | SU_W | Oscillator start-up length in cycles |
| ce_cpu | output | 1 | CPU clock enable |
| ce_flash | output | 1 | Flash clock enable |
| ce_io | output | 1 | I/O clock enable |
| ce_adc | output | 1 | ADC clock enable |
| osc_en | output | 1 | Main oscillator enable |
| cpu_run | output | 1 | CPU allowed to execute |
| vec_go | output | 1 | One-cycle strobe when the CPU is released |
| vec_rst | output | 1 | 1 = reset vector, 0 = interrupt |

## Verification
A wrong sequencer state shows on the enables one cycle after the edge that caused it. Each phase (sleep, start-up, halt, run) has its own enable pattern, so a wrong state cannot hide. A counter that is off by one moves the rise of `cpu_run` and `vec_go` by that many cycles. The bench catches this by checking the pattern on every cycle of start-up and halt. A lost reset flag or a stale latched mode shows as a wrong `vec_rst` at the next `vec_go`, or as a wrong gating pattern in the cycle right after sleep entry.

// File: rtl/slp_pkg.sv
package slp_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE  = 2'b00,
    MODE_ADCQ  = 2'b01,
    MODE_PDOWN = 2'b10,
    MODE_RSVD  = 2'b11
  } slp_mode_e;

  typedef enum logic [1:0] {
    ST_RUN     = 2'b00,
    ST_SLEEP   = 2'b01,
    ST_STARTUP = 2'b10,
    ST_HALT    = 2'b11
  } slp_state_e;

  // clock domain indices
  localparam int DOM_N     = 5;
  localparam int DOM_CPU   = 0;
  localparam int DOM_FLASH = 1;
  localparam int DOM_IO    = 2;
  localparam int DOM_ADC   = 3;
  localparam int DOM_OSC   = 4;

  // wake source indices
  localparam int SRC_N     = 5;
  localparam int SRC_EXT0  = 0;
  localparam int SRC_PCHG  = 1;
  localparam int SRC_WDOG  = 2;
  localparam int SRC_ADC   = 3;
  localparam int SRC_IO    = 4;

  // domains left running while asleep in a given mode
  function automatic logic [DOM_N-1:0] dom_keep(slp_mode_e m);
    logic [DOM_N-1:0] k;
    k = '0;
    case (m)
      MODE_IDLE: begin
        k[DOM_IO]  = 1'b1;
        k[DOM_ADC] = 1'b1;
        k[DOM_OSC] = 1'b1;
      end
      MODE_ADCQ: begin
        k[DOM_ADC] = 1'b1;
        k[DOM_OSC] = 1'b1;
      end
      default: k = '0;
    endcase
    return k;
  endfunction

  // wake sources honoured in a given mode
  function automatic logic [SRC_N-1:0] src_allow(slp_mode_e m);
    logic [SRC_N-1:0] a;
    a = '0;
    a[SRC_EXT0] = 1'b1;
    a[SRC_PCHG] = 1'b1;
    a[SRC_WDOG] = 1'b1;
    case (m)
      MODE_IDLE: begin
        a[SRC_ADC] = 1'b1;
        a[SRC_IO]  = 1'b1;
      end
      MODE_ADCQ: a[SRC_ADC] = 1'b1;
      default:   ;
    endcase
    return a;
  endfunction

  function automatic logic osc_stops(slp_mode_e m);
    return (m == MODE_PDOWN) || (m == MODE_RSVD);
  endfunction

endpackage

// File: rtl/slp_cfg_reg.sv
module slp_cfg_reg
  import slp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_ni,
  input  logic      we_i,
  input  logic      slp_en_i,
  input  logic [1:0] mode_i,
  input  logic      enter_i,
  output logic      slp_en_q_o,
  output slp_mode_e act_d_o,
  output slp_mode_e act_q_o
);

  logic      en_q, en_d;
  slp_mode_e mode_q, mode_d;
  slp_mode_e act_q, act_d;

  always_comb begin
    en_d   = en_q;
    mode_d = mode_q;
    if (we_i) begin
      en_d   = slp_en_i;
      mode_d = slp_mode_e'(mode_i);
    end
  end

  always_comb begin
    act_d = act_q;
    if (enter_i) act_d = mode_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      mode_q <= MODE_IDLE;
      act_q  <= MODE_IDLE;
    end else begin
      en_q   <= en_d;
      mode_q <= mode_d;
      act_q  <= act_d;
    end
  end

  assign slp_en_q_o = en_q;
  assign act_d_o    = act_d;
  assign act_q_o    = act_q;

endmodule

// File: rtl/slp_wake_filt.sv
module slp_wake_filt
  import slp_pkg::*;
#(
  parameter int EXT0_FILT = 2
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic [SRC_N-1:0] src_i,
  input  slp_mode_e        mode_i,
  output logic             wake_o
);

  logic             ext0_ok;
  logic [SRC_N-1:0] qual;

  generate
    if (EXT0_FILT > 1) begin : g_filt
      localparam int HW = EXT0_FILT - 1;
      logic [HW-1:0] hist_q, hist_d;

      always_comb hist_d = HW'({hist_q, src_i[SRC_EXT0]});

      always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) hist_q <= '0;
        else         hist_q <= hist_d;
      end

      assign ext0_ok = src_i[SRC_EXT0] & (&hist_q);
    end else begin : g_nofilt
      assign ext0_ok = src_i[SRC_EXT0];
    end
  endgenerate

  always_comb begin
    qual           = src_i;
    qual[SRC_EXT0] = ext0_ok;
  end

  assign wake_o = |(qual & src_allow(mode_i));

endmodule

// File: rtl/slp_seq.sv
module slp_seq
  import slp_pkg::*;
#(
  parameter int SU_W     = 8,
  parameter int HALT_CYC = 4
) (
  input  logic            clk,
  input  logic            rst_ni,
  input  logic            slp_req_i,
  input  logic            slp_en_i,
  input  slp_mode_e       mode_i,
  input  logic            wake_i,
  input  logic            core_rst_i,
  input  logic [SU_W-1:0] su_i,
  output slp_state_e      st_d_o,
  output logic            enter_o,
  output logic            go_d_o,
  output logic            rflag_d_o
);

  localparam int HCW = $clog2(HALT_CYC + 1);
  localparam int CW  = (SU_W > HCW) ? SU_W : HCW;
  localparam logic [CW-1:0] HALT_LOAD = CW'(HALT_CYC - 1);

  slp_state_e    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          rflag_q, rflag_d;
  logic          enter, go_d;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    rflag_d = rflag_q;
    enter   = 1'b0;
    go_d    = 1'b0;
    case (st_q)
      ST_RUN: begin
        if (slp_req_i && slp_en_i) begin
          st_d    = ST_SLEEP;
          rflag_d = 1'b0;
          enter   = 1'b1;
        end
      end
      ST_SLEEP: begin
        if (wake_i || core_rst_i) begin
          rflag_d = rflag_q | core_rst_i;
          if (osc_stops(mode_i) && (su_i != '0)) begin
            st_d  = ST_STARTUP;
            cnt_d = CW'(su_i) - CW'(1);
          end else begin
            st_d  = ST_HALT;
            cnt_d = HALT_LOAD;
          end
        end
      end
      ST_STARTUP: begin
        rflag_d = rflag_q | core_rst_i;
        if (cnt_q == '0) begin
          st_d  = ST_HALT;
          cnt_d = HALT_LOAD;
        end else begin
          cnt_d = cnt_q - CW'(1);
        end
      end
      ST_HALT: begin
        rflag_d = rflag_q | core_rst_i;
        if (cnt_q == '0) begin
          st_d = ST_RUN;
          go_d = 1'b1;
        end else begin
          cnt_d = cnt_q - CW'(1);
        end
      end
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_RUN;
      cnt_q   <= '0;
      rflag_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      rflag_q <= rflag_d;
    end
  end

  assign st_d_o    = st_d;
  assign enter_o   = enter;
  assign go_d_o    = go_d;
  assign rflag_d_o = rflag_d;

endmodule

// File: rtl/slp_out_reg.sv
module slp_out_reg
  import slp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_ni,
  input  slp_state_e       st_d_i,
  input  slp_mode_e        mode_d_i,
  input  logic             go_d_i,
  input  logic             rflag_d_i,
  output logic [DOM_N-1:0] en_o,
  output logic             run_o,
  output logic             go_o,
  output logic             rvec_o
);

  localparam logic [DOM_N-1:0] OSC_ONLY = DOM_N'(1) << DOM_OSC;
  localparam logic [DOM_N-1:0] NO_CPU   = ~(DOM_N'(1) << DOM_CPU);

  logic [DOM_N-1:0] en_d;
  logic             run_d;

  always_comb begin
    case (st_d_i)
      ST_RUN:     en_d = '1;
      ST_SLEEP:   en_d = dom_keep(mode_d_i);
      ST_STARTUP: en_d = OSC_ONLY;
      ST_HALT:    en_d = NO_CPU;
      default:    en_d = '1;
    endcase
    run_d = (st_d_i == ST_RUN);
  end

  generate
    for (genvar d = 0; d < DOM_N; d++) begin : g_dom
      logic en_q;
      always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) en_q <= 1'b1;
        else         en_q <= en_d[d];
      end
      assign en_o[d] = en_q;
    end
  endgenerate

  logic run_q, go_q, rvec_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b1;
      go_q   <= 1'b0;
      rvec_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      go_q   <= go_d_i;
      rvec_q <= rflag_d_i;
    end
  end

  assign run_o  = run_q;
  assign go_o   = go_q;
  assign rvec_o = rvec_q;

endmodule

// File: rtl/sleep_clkgate_ctrl.sv
module sleep_clkgate_ctrl
  import slp_pkg::*;
#(
  parameter int SU_W      = 8,
  parameter int HALT_CYC  = 4,
  parameter int EXT0_FILT = 2
) (
  input  logic            clk_ref,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic            cfg_slp_en,
  input  logic [1:0]      cfg_mode,
  input  logic            slp_req,
  input  logic            core_rst,
  input  logic            wake_ext0,
  input  logic            wake_pinchg,
  input  logic            wake_wdog,
  input  logic            wake_adc,
  input  logic            wake_io,
  input  logic [SU_W-1:0] su_cycles,
  output logic            ce_cpu,
  output logic            ce_flash,
  output logic            ce_io,
  output logic            ce_adc,
  output logic            osc_en,
  output logic            cpu_run,
  output logic            vec_go,
  output logic            vec_rst
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sync_n = rsync_q[1];

  logic             slp_en_q;
  slp_mode_e        act_d, act_q;
  logic             enter, wake, go_d, rflag_d;
  slp_state_e       st_d;
  logic [SRC_N-1:0] src;
  logic [DOM_N-1:0] en;

  always_comb begin
    src           = '0;
    src[SRC_EXT0] = wake_ext0;
    src[SRC_PCHG] = wake_pinchg;
    src[SRC_WDOG] = wake_wdog;
    src[SRC_ADC]  = wake_adc;
    src[SRC_IO]   = wake_io;
  end

  slp_cfg_reg i_cfg (
    .clk        (clk_ref),
    .rst_ni     (rst_sync_n),
    .we_i       (cfg_we),
    .slp_en_i   (cfg_slp_en),
    .mode_i     (cfg_mode),
    .enter_i    (enter),
    .slp_en_q_o (slp_en_q),
    .act_d_o    (act_d),
    .act_q_o    (act_q)
  );

  slp_wake_filt #(.EXT0_FILT(EXT0_FILT)) i_wake (
    .clk    (clk_ref),
    .rst_ni (rst_sync_n),
    .src_i  (src),
    .mode_i (act_q),
    .wake_o (wake)
  );

  slp_seq #(.SU_W(SU_W), .HALT_CYC(HALT_CYC)) i_seq (
    .clk        (clk_ref),
    .rst_ni     (rst_sync_n),
    .slp_req_i  (slp_req),
    .slp_en_i   (slp_en_q),
    .mode_i     (act_q),
    .wake_i     (wake),
    .core_rst_i (core_rst),
    .su_i       (su_cycles),
    .st_d_o     (st_d),
    .enter_o    (enter),
    .go_d_o     (go_d),
    .rflag_d_o  (rflag_d)
  );

  slp_out_reg i_out (
    .clk       (clk_ref),
    .rst_ni    (rst_sync_n),
    .st_d_i    (st_d),
    .mode_d_i  (act_d),
    .go_d_i    (go_d),
    .rflag_d_i (rflag_d),
    .en_o      (en),
    .run_o     (cpu_run),
    .go_o      (vec_go),
    .rvec_o    (vec_rst)
  );

  assign ce_cpu   = en[DOM_CPU];
  assign ce_flash = en[DOM_FLASH];
  assign ce_io    = en[DOM_IO];
  assign ce_adc   = en[DOM_ADC];
  assign osc_en   = en[DOM_OSC];

endmodule

// File: rtl/slp_ctrl_chk.sv
module slp_ctrl_chk #(
  parameter int HALT_CYC = 4
) (
  input logic clk,
  input logic rst_ni,
  input logic slp_req,
  input logic slp_en_q,
  input logic ce_cpu,
  input logic ce_flash,
  input logic ce_io,
  input logic ce_adc,
  input logic osc_en,
  input logic cpu_run,
  input logic vec_go,
  input logic vec_rst
);

  logic       halt_sig;
  logic [7:0] hcnt_q;

  assign halt_sig = !cpu_run && ce_flash;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)                      hcnt_q <= '0;
    else if (!halt_sig)               hcnt_q <= '0;
    else if (hcnt_q != 8'hFF)         hcnt_q <= hcnt_q + 8'd1;
  end

  p_run_all_on_r1: assert property (@(posedge clk) disable iff (!rst_ni)
    cpu_run |-> (ce_cpu && ce_flash && ce_io && ce_adc && osc_en));

  p_ignore_clear_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    (cpu_run && slp_req && !slp_en_q) |=> cpu_run);

  p_cpu_gated_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    !cpu_run |-> !ce_cpu);

  p_flash_needs_osc_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    (ce_flash || ce_io || ce_adc) |-> osc_en);

  p_halt_bound_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    halt_sig |-> (hcnt_q < 8'(HALT_CYC)));

  p_halt_len_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(cpu_run) |-> (vec_go && hcnt_q == 8'(HALT_CYC)));

  p_go_in_run_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    vec_go |-> cpu_run);

  p_vec_steady_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    (cpu_run && $past(cpu_run)) |-> $stable(vec_rst));

endmodule

bind sleep_clkgate_ctrl slp_ctrl_chk #(.HALT_CYC(HALT_CYC)) i_chk (
  .clk      (clk_ref),
  .rst_ni   (rst_sync_n),
  .slp_req  (slp_req),
  .slp_en_q (slp_en_q),
  .ce_cpu   (ce_cpu),
  .ce_flash (ce_flash),
  .ce_io    (ce_io),
  .ce_adc   (ce_adc),
  .osc_en   (osc_en),
  .cpu_run  (cpu_run),
  .vec_go   (vec_go),
  .vec_rst  (vec_rst)
);

// File: tb/test_sleep_clkgate_ctrl.sv
module test_sleep_clkgate_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int SU_W       = 8;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rst_n, cfg_we, cfg_slp_en, slp_req, core_rst;
  logic [1:0] cfg_mode;
  logic wake_ext0, wake_pinchg, wake_wdog, wake_adc, wake_io;
  logic [SU_W-1:0] su_cycles;
  logic ce_cpu, ce_flash, ce_io, ce_adc, osc_en, cpu_run, vec_go, vec_rst;

  sleep_clkgate_ctrl #(.SU_W(SU_W)) i_sleep_clkgate_ctrl (
    .clk_ref(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_slp_en(cfg_slp_en),
    .cfg_mode(cfg_mode), .slp_req(slp_req), .core_rst(core_rst),
    .wake_ext0(wake_ext0), .wake_pinchg(wake_pinchg), .wake_wdog(wake_wdog),
    .wake_adc(wake_adc), .wake_io(wake_io), .su_cycles(su_cycles),
    .ce_cpu(ce_cpu), .ce_flash(ce_flash), .ce_io(ce_io), .ce_adc(ce_adc),
    .osc_en(osc_en), .cpu_run(cpu_run), .vec_go(vec_go), .vec_rst(vec_rst)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // {mode, src mask (io,adc,wdog,pinchg,ext0), wake expected}
  localparam int NV = 14;
  localparam logic [7:0] VEC [NV] = '{
    {2'b00, 5'b10000, 1'b1},
    {2'b00, 5'b01000, 1'b1},
    {2'b00, 5'b00100, 1'b1},
    {2'b01, 5'b10000, 1'b0},
    {2'b01, 5'b01000, 1'b1},
    {2'b01, 5'b00100, 1'b1},
    {2'b01, 5'b00010, 1'b1},
    {2'b10, 5'b01000, 1'b0},
    {2'b10, 5'b10000, 1'b0},
    {2'b10, 5'b00100, 1'b1},
    {2'b10, 5'b00001, 1'b1},
    {2'b10, 5'b00010, 1'b1},
    {2'b11, 5'b10000, 1'b0},
    {2'b11, 5'b00001, 1'b1}
  };

  function automatic logic [4:0] exp_en(logic [1:0] m);
    case (m)
      2'b00:   return 5'b11100;
      2'b01:   return 5'b11000;
      default: return 5'b00000;
    endcase
  endfunction

  function automatic logic [4:0] en_now();
    return {osc_en, ce_adc, ce_io, ce_flash, ce_cpu};
  endfunction

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr_cfg(logic en, logic [1:0] m);
    cfg_we = 1'b1; cfg_slp_en = en; cfg_mode = m;
    cyc(1);
    cfg_we = 1'b0;
  endtask

  task automatic go_sleep();
    slp_req = 1'b1;
    cyc(1);
    slp_req = 1'b0;
  endtask

  task automatic set_src(logic [4:0] s);
    {wake_io, wake_adc, wake_wdog, wake_pinchg, wake_ext0} = s;
  endtask

  task automatic pchg_wake();
    wake_pinchg = 1'b1;
    cyc(1);
    wake_pinchg = 1'b0;
    cyc(5);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL run limit: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_slp_en = 1'b0; cfg_mode = 2'b00;
    slp_req = 1'b0; core_rst = 1'b0; su_cycles = '0;
    set_src(5'b00000);
    cyc(3);
    // R1: reset state
    chk("R1 enables in reset", 32'(en_now()), 32'h1F);
    chk("R1 run in reset", 32'({cpu_run, vec_go, vec_rst}), 32'b100);
    rst_n = 1'b1;
    cyc(4);
    chk("R1 after release", 32'({en_now(), cpu_run, vec_go, vec_rst}), 32'b11111100);

    // R2: request with enable bit clear
    wr_cfg(1'b0, 2'b10);
    go_sleep();
    chk("R2 request ignored", 32'({en_now(), cpu_run}), 32'b111111);
    cyc(3);
    chk("R2 still running", 32'({en_now(), cpu_run}), 32'b111111);

    // vector table: R3 R4 R5 gating, R6 filtering, R7 two-cycle ext0
    for (int i = 0; i < NV; i++) begin
      logic [1:0] m;
      logic [4:0] s;
      logic       w;
      {m, s, w} = VEC[i];
      wr_cfg(1'b1, m);
      go_sleep();
      chk(m == 2'b00 ? "R3 idle gating" : (m == 2'b01 ? "R4 adc-quiet gating" : "R5 power-down gating"),
          32'({en_now(), cpu_run}), 32'({exp_en(m), 1'b0}));
      set_src(s);
      cyc(2);
      set_src(5'b00000);
      cyc(5);
      chk(s[0] ? "R7 ext0 held two cycles" : "R6 wake source filter", 32'(cpu_run), 32'(w));
      if (!w) pchg_wake();
    end

    // R11: mode captured at entry
    wr_cfg(1'b1, 2'b00);
    go_sleep();
    wr_cfg(1'b1, 2'b10);
    cyc(1);
    chk("R11 gating kept during sleep", 32'(en_now()), 32'(5'b11100));
    pchg_wake();
    go_sleep();
    chk("R11 new mode next sleep", 32'(en_now()), 32'(5'b00000));

    // R7: one-cycle ext0 pulse in power-down
    wake_ext0 = 1'b1;
    cyc(1);
    wake_ext0 = 1'b0;
    cyc(6);
    chk("R7 short pulse ignored", 32'({cpu_run, osc_en}), 32'b00);
    pchg_wake();
    chk("R10 interrupt wake vector", 32'(vec_rst), 32'(0));

    // R8 and R9: start-up then halt from power-down
    su_cycles = 8'd5;
    go_sleep();
    wake_pinchg = 1'b1;
    cyc(1);
    wake_pinchg = 1'b0;
    for (int k = 0; k < 5; k++) begin
      chk("R8 start-up osc only", 32'({en_now(), cpu_run}), 32'b100000);
      cyc(1);
    end
    for (int k = 0; k < 4; k++) begin
      chk("R9 halt pattern", 32'({en_now(), cpu_run, vec_go}), 32'b1111000);
      cyc(1);
    end
    chk("R9 release", 32'({cpu_run, vec_go, vec_rst}), 32'b110);
    cyc(1);
    chk("R9 strobe one cycle", 32'(vec_go), 32'(0));

    // R8: idle skips start-up even with nonzero count
    wr_cfg(1'b1, 2'b00);
    go_sleep();
    wake_wdog = 1'b1;
    cyc(1);
    wake_wdog = 1'b0;
    chk("R8 idle no start-up", 32'({en_now(), cpu_run}), 32'b111100);
    cyc(4);
    chk("R9 idle release", 32'({cpu_run, vec_go}), 32'b11);

    // R10: reset event during power-down sleep
    su_cycles = '0;
    wr_cfg(1'b1, 2'b10);
    go_sleep();
    core_rst = 1'b1;
    cyc(1);
    core_rst = 1'b0;
    chk("R10 reset wakes", 32'(en_now()), 32'(5'b11110));
    cyc(4);
    chk("R10 reset vector", 32'({cpu_run, vec_go, vec_rst}), 32'b111);
    cyc(2);
    chk("R10 vector held in run", 32'(vec_rst), 32'(1));
    go_sleep();
    pchg_wake();
    chk("R10 flag cleared for interrupt", 32'({cpu_run, vec_rst}), 32'b10);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule